// File: doc/BRIEF.md
# Chip Event Data Serial Readout

This block streams one chip's stored event record out over a single serial line once conversion has finished. A start request, accepted while the block is idle, raises a transmit-active flag. The block then sends the chip identifier. After that it sends every filled event column. A column carries its bunch-crossing stamp followed by the time and charge words of every channel. Each of these words leads with its gain-range flag.

The block advances one bit per readout clock and leaves no gaps between words. The readout clock may run at 1 MHz or at 5 MHz. Column data comes from a synchronous RAM with a read latency of one cycle. The block fetches the next word while the current one is still shifting out.

When the last bit has gone out, transmit-active drops and an end pulse lasting one clock is raised. The next chip on a shared line waits for this pulse before it starts its own transfer.

Top module: `chip_readout_serializer`

## Requirements
- R1: While rst_n is low at a clock edge, tx_on, sdata, end_rd and ram_rd_en are all low after that edge.
- R2: When start_rd is high at an edge while tx_on is low, tx_on is high from that edge on. start_rd is ignored while tx_on is high.
- R3: The first 8 bits of a frame are chip_id, most significant bit first. The first of them is on sdata in the cycle in which tx_on first goes high.
- R4: Each filled column c occupies RAM words c*73 to c*73+72. The frame sends the column's stamp, which is bits 7..0 of word c*73. It then sends, for channels k = 0 to 35 in turn, the time word at c*73+1+2k and then the charge word at c*73+2+2k. Each of these is 13 bits: bit 12 is the gain flag and goes first, followed by the 12-bit value, MSB first.
- R5: One bit is sent per clock with no idle cycles, so a frame lasts 8 + 944·n cycles for n columns.
- R6: The column count n is fill_count, taken when the frame starts. Values above 16 count as 16, and 0 sends only the chip ID.
- R7: end_rd is high for exactly one cycle, the cycle right after the last bit. tx_on falls at the same edge at which end_rd rises.
- R8: sdata is low whenever tx_on is low.
- R9: ram_rd_en is high only while tx_on is high, and only with addresses below 73·n.
- R10: Changes to chip_id or fill_count after a frame has started have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_rd | input | 1 | Readout request |
| chip_id | input | 8 | Chip identifier sent at the head of the frame |
| fill_count | input | 5 | Number of filled columns |
| ram_rd_en | output | 1 | RAM read strobe |
| ram_addr | output | 11 | RAM read address |
| ram_rdata | input | 13 | RAM read data, valid one cycle after the strobe |
| sdata | output | 1 | Serial data, MSB first |
| tx_on | output | 1 | Frame in progress |
| end_rd | output | 1 | One-cycle end-of-readout pulse |

## Verification
Frames are run with column counts of 0, 1, 2, 3 and 16, and with a count of 20.
- The zero-column case isolates the chip-ID header and the end handshake.
- The one- and two-column cases show whether column boundaries and the stamp-versus-channel word widths are handled correctly.
- The full and over-range counts exercise the largest address and the clamp to 16.

The RAM is given a different address-dependent pattern for each frame, so a swap of time and charge words, a dropped gain flag or an off-by-one address shows up as wrong bits.

In one frame, the chip ID and the column count are changed part-way through and a second start is raised. This separates values captured at the start from live inputs, and it checks that the block ignores a request while busy.

// File: rtl/ro_pkg.sv
// Package: shared types and helpers for the serial readout block.
// Assumes nothing beyond IEEE 1800-2017 constant functions.
package ro_pkg;

    typedef enum logic {
        RO_IDLE = 1'b0,
        RO_SEND = 1'b1
    } ro_state_e;

    // Largest of three widths, used to size the shift register.
    function automatic int ro_max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ro_word_seq.sv
// Module: ro_word_seq
// Generates the RAM read sequence for one frame: one fetch at frame start,
// then one fetch for every word consumed while more words remain.
// Tracks whether the fetched word is a column stamp (first word of a column).
// Assumes a RAM with one cycle of read latency whose output holds between reads.
module ro_word_seq #(
    parameter int N_COL = 16,
    parameter int WPC   = 73,
    parameter int CNT_W = 5,
    parameter int AW    = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             adv,
    input  logic [CNT_W-1:0] fill_count,
    output logic             rd_en,
    output logic [AW-1:0]    addr,
    output logic             have_word,
    output logic             word_is_stamp
);
    localparam int WL_W  = $clog2(N_COL * WPC + 1);
    localparam int POS_W = (WPC > 1) ? $clog2(WPC) : 1;
    localparam logic [CNT_W-1:0] COL_MAX  = CNT_W'(N_COL);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(WPC - 1);

    logic [CNT_W-1:0] cols;
    logic [WL_W-1:0]  total;
    logic [WL_W-1:0]  words_left;
    logic [POS_W-1:0] pos;

    // Clamp the requested column count and derive the frame's word total.
    always_comb begin
        cols  = (fill_count > COL_MAX) ? COL_MAX : fill_count;
        total = WL_W'(cols) * WL_W'(WPC);
    end

    // Issue fetches and track the remaining words and the position within a column.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_left    <= '0;
            addr          <= '0;
            rd_en         <= 1'b0;
            pos           <= '0;
            word_is_stamp <= 1'b0;
        end else begin
            rd_en <= 1'b0;
            if (go) begin
                words_left    <= total;
                addr          <= '0;
                pos           <= '0;
                word_is_stamp <= 1'b1;
                rd_en         <= (total != '0);
            end else if (adv && (words_left != '0)) begin
                words_left <= words_left - 1'b1;
                if (words_left > WL_W'(1)) begin
                    rd_en <= 1'b1;
                    addr  <= addr + 1'b1;
                    if (pos == POS_LAST) begin
                        pos           <= '0;
                        word_is_stamp <= 1'b1;
                    end else begin
                        pos           <= pos + 1'b1;
                        word_is_stamp <= 1'b0;
                    end
                end
            end
        end
    end

    assign have_word = (words_left != '0);

endmodule

// File: rtl/ro_shifter.sv
// Module: ro_shifter
// Left-aligned shift register with a remaining-bit counter. It loads the chip ID,
// a column stamp or a full channel word, and shifts one bit per enabled cycle.
// Assumes ID_W, STAMP_W and WORD_W are each no larger than SH_W.
module ro_shifter #(
    parameter int ID_W    = 8,
    parameter int STAMP_W = 8,
    parameter int WORD_W  = 13,
    parameter int SH_W    = 13,
    parameter int BC_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_id,
    input  logic              load_word,
    input  logic              word_is_stamp,
    input  logic [ID_W-1:0]   chip_id,
    input  logic [WORD_W-1:0] word,
    input  logic              shift,
    output logic              msb,
    output logic              last
);
    logic [SH_W-1:0] shreg;
    logic [BC_W-1:0] bcnt;

    // Load a new field left-aligned, or advance the current field by one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            bcnt  <= '0;
        end else if (load_id) begin
            shreg <= SH_W'(chip_id) << (SH_W - ID_W);
            bcnt  <= BC_W'(ID_W);
        end else if (load_word) begin
            if (word_is_stamp) begin
                shreg <= SH_W'(word[STAMP_W-1:0]) << (SH_W - STAMP_W);
                bcnt  <= BC_W'(STAMP_W);
            end else begin
                shreg <= SH_W'(word) << (SH_W - WORD_W);
                bcnt  <= BC_W'(WORD_W);
            end
        end else if (shift) begin
            shreg <= shreg << 1;
            bcnt  <= bcnt - 1'b1;
        end
    end

    assign msb  = shreg[SH_W-1];
    assign last = (bcnt == BC_W'(1));

endmodule

// File: rtl/ro_ctrl.sv
// Module: ro_ctrl
// Two-state frame controller. It accepts a start request only when idle, then
// per bit decides whether to shift, load the next word or close the frame.
// Assumes the shifter's last flag marks the final bit of the current field.
module ro_ctrl
    import ro_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_rd,
    input  logic last,
    input  logic have_word,
    output logic go,
    output logic load_word,
    output logic shift,
    output logic tx_on,
    output logic end_rd
);
    ro_state_e st;
    logic      finish;

    // Per-cycle decisions derived from the state and the bit position.
    always_comb begin
        go        = (st == RO_IDLE) && start_rd;
        load_word = (st == RO_SEND) && last && have_word;
        finish    = (st == RO_SEND) && last && !have_word;
        shift     = (st == RO_SEND) && !last;
    end

    // State register and one-cycle end pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= RO_IDLE;
            end_rd <= 1'b0;
        end else begin
            end_rd <= finish;
            if (go) begin
                st <= RO_SEND;
            end else if (finish) begin
                st <= RO_IDLE;
            end
        end
    end

    assign tx_on = (st == RO_SEND);

endmodule

// File: rtl/chip_readout_serializer.sv
// Module: chip_readout_serializer
// Top level of the serial readout block. It sends the chip ID, then for each filled
// column a stamp and per-channel time and charge words with gain flags, MSB first,
// one bit per clock, and ends with a one-cycle end pulse.
// Assumes a synchronous RAM with one cycle of read latency, laid out as WPC words per column.
module chip_readout_serializer
    import ro_pkg::*;
#(
    parameter int ID_W    = 8,
    parameter int STAMP_W = 8,
    parameter int SAMP_W  = 12,
    parameter int N_CH    = 36,
    parameter int N_COL   = 16,
    localparam int WORD_W = SAMP_W + 1,
    localparam int WPC    = 1 + 2 * N_CH,
    localparam int DEPTH  = N_COL * WPC,
    localparam int AW     = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(N_COL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_rd,
    input  logic [ID_W-1:0]   chip_id,
    input  logic [CNT_W-1:0]  fill_count,
    output logic              ram_rd_en,
    output logic [AW-1:0]     ram_addr,
    input  logic [WORD_W-1:0] ram_rdata,
    output logic              sdata,
    output logic              tx_on,
    output logic              end_rd
);
    localparam int SH_W = ro_max3(ID_W, STAMP_W, WORD_W);
    localparam int BC_W = $clog2(SH_W + 1);

    logic go, load_word, shift, last, have_word, word_is_stamp, msb;

    ro_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_rd  (start_rd),
        .last      (last),
        .have_word (have_word),
        .go        (go),
        .load_word (load_word),
        .shift     (shift),
        .tx_on     (tx_on),
        .end_rd    (end_rd)
    );

    ro_word_seq #(
        .N_COL (N_COL),
        .WPC   (WPC),
        .CNT_W (CNT_W),
        .AW    (AW)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .go            (go),
        .adv           (load_word),
        .fill_count    (fill_count),
        .rd_en         (ram_rd_en),
        .addr          (ram_addr),
        .have_word     (have_word),
        .word_is_stamp (word_is_stamp)
    );

    ro_shifter #(
        .ID_W    (ID_W),
        .STAMP_W (STAMP_W),
        .WORD_W  (WORD_W),
        .SH_W    (SH_W),
        .BC_W    (BC_W)
    ) u_shift (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_id       (go),
        .load_word     (load_word),
        .word_is_stamp (word_is_stamp),
        .chip_id       (chip_id),
        .word          (ram_rdata),
        .shift         (shift),
        .msb           (msb),
        .last          (last)
    );

    // The line carries data only during a frame.
    assign sdata = tx_on & msb;

endmodule

// File: rtl/ro_checker.sv
// Module: ro_checker
// Temporal properties of the readout block's ports, attached by bind.
// Assumes reset is held for at least one clock edge before release.
module ro_checker #(
    parameter int AW    = 11,
    parameter int DEPTH = 1168
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_rd,
    input logic          tx_on,
    input logic          sdata,
    input logic          end_rd,
    input logic          ram_rd_en,
    input logic [AW-1:0] ram_addr
);
    // R2: an idle start opens a frame
    a_r2_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (start_rd && !tx_on) |=> tx_on);

    // R5: a frame never closes right after opening (header is several bits)
    a_r5_min_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_on) |=> tx_on);

    // R7: end pulse lasts one cycle
    a_r7_end_single: assert property (@(posedge clk) disable iff (!rst_n)
        end_rd |=> !end_rd);

    // R7: end pulse coincides exactly with the fall of tx_on
    a_r7_end_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        end_rd == $fell(tx_on));

    // R8: line quiet outside a frame
    a_r8_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_on |-> !sdata);

    // R9: reads only inside a frame
    a_r9_read_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_en |-> tx_on);

    // R9: read address inside the storage
    a_r9_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_en |-> (int'(ram_addr) < DEPTH));

endmodule

bind chip_readout_serializer ro_checker #(.AW(AW), .DEPTH(DEPTH)) u_ro_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_rd  (start_rd),
    .tx_on     (tx_on),
    .sdata     (sdata),
    .end_rd    (end_rd),
    .ram_rd_en (ram_rd_en),
    .ram_addr  (ram_addr)
);

// File: tb/chip_readout_serializer_test.sv
// Bench: behavioural reference model (bit queue) compared with the outputs every clock.
module chip_readout_serializer_test;
    localparam int WPC    = 73;
    localparam int DEPTH  = 16 * WPC;
    localparam int STRIDE = 944;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_rd = 1'b0;
    logic [7:0]  chip_id = 8'h00;
    logic [4:0]  fill_count = 5'd0;
    logic        ram_rd_en;
    logic [10:0] ram_addr;
    logic [12:0] ram_rdata = '0;
    logic        sdata, tx_on, end_rd;

    logic [12:0] mem [0:DEPTH-1];

    int checks = 0, fails = 0, cyc = 0, tx_cycles = 0;
    bit seen_edge = 0, done = 0;

    bit q[$];
    int m_busy = 0, m_end = 0, m_idx = 0, m_n = 0;

    always #10 clk = ~clk;

    chip_readout_serializer uut (
        .clk(clk), .rst_n(rst_n), .start_rd(start_rd), .chip_id(chip_id),
        .fill_count(fill_count), .ram_rd_en(ram_rd_en), .ram_addr(ram_addr),
        .ram_rdata(ram_rdata), .sdata(sdata), .tx_on(tx_on), .end_rd(end_rd)
    );

    // Synchronous RAM with one cycle of latency.
    always @(posedge clk) if (ram_rd_en) ram_rdata <= mem[ram_addr];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    task automatic fill_ram(input int seed);
        for (int a = 0; a < DEPTH; a++)
            mem[a] = 13'((a * 29 + seed * 611 + (a / 7) * 3) ^ (seed << 4));
    endtask

    // Expected frame built straight from the requirement text (R3, R4, R6).
    task automatic build(input logic [7:0] id, input logic [4:0] fc);
        m_n = (fc > 5'd16) ? 16 : int'(fc);
        q.delete();
        for (int i = 7; i >= 0; i--) q.push_back(id[i]);
        for (int c = 0; c < m_n; c++) begin
            for (int i = 7; i >= 0; i--) q.push_back(mem[c * WPC][i]);
            for (int k = 0; k < 36; k++) begin
                for (int i = 12; i >= 0; i--) q.push_back(mem[c * WPC + 1 + 2 * k][i]);
                for (int i = 12; i >= 0; i--) q.push_back(mem[c * WPC + 2 + 2 * k][i]);
            end
        end
    endtask

    // Reference model, advanced on each clock edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            q.delete();
            m_busy = 0; m_end = 0; m_idx = 0;
        end else begin
            m_end = 0;
            if (m_busy != 0) begin
                void'(q.pop_front());
                m_idx++;
                if (q.size() == 0) begin m_busy = 0; m_end = 1; end
            end else if (start_rd) begin
                build(chip_id, fill_count);
                m_busy = 1; m_idx = 0;
            end
        end
        seen_edge = 1;
    end

    // Cycle compare, away from the active edge.
    always @(negedge clk) if (seen_edge && !done) begin
        if (!rst_n) begin
            chk({tx_on, sdata, end_rd, ram_rd_en} === 4'b0, "R1 reset outputs",
                int'({tx_on, sdata, end_rd, ram_rd_en}), 0);
        end else begin
            chk(tx_on === (m_busy != 0), "R2/R7 tx_on", int'(tx_on), m_busy);
            if (m_busy == 0)
                chk(sdata === 1'b0, "R8 sdata idle", int'(sdata), 0);
            else if (m_idx < 8)
                chk(sdata === q[0], "R3 chip id bit", int'(sdata), int'(q[0]));
            else
                chk(sdata === q[0], "R4 column bit", int'(sdata), int'(q[0]));
            chk(end_rd === (m_end != 0), "R7 end pulse", int'(end_rd), m_end);
            if (ram_rd_en === 1'b1)
                chk(tx_on === 1'b1 && int'(ram_addr) < m_n * WPC, "R9 read window",
                    int'(ram_addr), m_n * WPC);
            if (tx_on === 1'b1) tx_cycles++;
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) if (cyc > 190000 && !done) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected below %0d", cyc, 190000);
        finish_up();
    end

    task automatic run_frame(input logic [7:0] id, input logic [4:0] fc, input int seed,
                             input bit disturb, input string tag);
        int n;
        n = (fc > 5'd16) ? 16 : int'(fc);
        fill_ram(seed);
        chip_id = id; fill_count = fc; tx_cycles = 0;
        @(negedge clk) start_rd = 1'b1;
        @(negedge clk) start_rd = 1'b0;
        if (disturb) begin
            repeat (20) @(negedge clk);
            chip_id = ~id; fill_count = 5'd7; start_rd = 1'b1;    // R10 and R2: ignored mid-frame
            @(negedge clk) start_rd = 1'b0;
        end
        while (m_busy != 0 || m_end != 0) @(negedge clk);
        chk(tx_cycles == 8 + n * STRIDE, tag, tx_cycles, 8 + n * STRIDE);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        fill_ram(0);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({tx_on, sdata, end_rd} === 3'b0, "R1 idle after reset", int'({tx_on, sdata, end_rd}), 0);
        run_frame(8'hA5, 5'd0,  1, 0, "R6 zero columns length");
        run_frame(8'h3C, 5'd1,  2, 0, "R5 one column length");
        run_frame(8'h96, 5'd2,  3, 0, "R5 two columns length");
        run_frame(8'h5A, 5'd16, 4, 0, "R5 full frame length");
        run_frame(8'hE1, 5'd20, 5, 0, "R6 clamp to 16 length");
        run_frame(8'h33, 5'd3,  6, 1, "R10 captured inputs length");
        finish_up();
    end
endmodule